// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This peripheral divides its clock by a programmable 16-bit factor and uses the result to advance a 32-bit up-counter. With the factor set to the clock rate in hertz, the counter counts seconds. Software cannot load the counter. It can only send it back to zero, and the same command restarts the divider. A 32-bit alarm word is compared with the counter on every increment. Two sticky status flags record an alarm match and a counter step.

A level interrupt is raised while any flag is set and its enable bit is set. Software reaches four word registers over a simple single-cycle read/write bus. Read data is combinational from the address. Reading the status word returns both flags and clears them.

Register map (byte offsets; bits [3:2] of the address select the word):

| Offset | Word | Contents |
|---|---|---|
| 0x00 | mode | divider factor, two interrupt enables, restart command |
| 0x04 | alarm | alarm compare value |
| 0x08 | counter | current count, read-only |
| 0x0C | status | alarm flag, step flag; cleared by a read |

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset, the mode word (0x00) reads 0x0000_8000, the alarm word (0x04) reads 0xFFFF_FFFF, the counter (0x08) and the status word (0x0C) read 0, and irq is low.
- R2: The counter at 0x08 advances by exactly one every P clock cycles, where P is mode bits [15:0].
- R3: Mode bits [15:0], bit 16 (alarm interrupt enable) and bit 17 (step interrupt enable) read back as written. Bit 18 and bits [31:19] always read 0.
- R4: A write to the mode word with bit 18 set clears the counter and the divider at that clock edge, and also loads the new mode bits. The first step after it comes P cycles later.
- R5: The counter word is read-only: a write to 0x08 leaves the count unchanged.
- R6: Status bit 0 sets on the step at which the counter becomes equal to the alarm word. It never sets while the alarm word is 0xFFFF_FFFF.
- R7: Status bit 1 sets on every counter step.
- R8: A read of 0x0C returns the flags and clears them. A flag whose event occurs in the same cycle as the read stays set.
- R9: irq is high exactly while some status bit i is set together with mode bit 16+i.
- R10: A divider value of 0 gives 65536 clock cycles per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the divider counts |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address; bits [3:2] pick the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties check on every cycle that:
- a restart zeroes the counter;
- the count holds between steps and moves by exactly one on a step;
- every event lands in its flag, even in a status-read cycle;
- a read clears any flag without a coincident event;
- a rising alarm flag always coincides with the counter equalling a live alarm word.

Only the directed scenarios can show the things that depend on how software uses the block:
- the exact step period for a given divider, including the 0 = 65536 case;
- readback masking of the restart bit;
- that a write to the counter is ignored;
- the irq gating by each enable;
- the cycle at which an alarm fires.

// File: rtl/tick_alarm_pkg.sv
package tick_alarm_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W = 32;
  localparam int PRE_W = 16;
  localparam int NUM_EVT = 2;
  localparam int ALM_EN_BIT = PRE_W;
  localparam int INC_EN_BIT = PRE_W + 1;
  localparam int RESTART_BIT = PRE_W + 2;
  localparam logic [PRE_W-1:0] PRE_RESET = 16'h8000;
  localparam logic [CNT_W-1:0] ALARM_OFF = '1;
  localparam int EVT_ALM = 0;
  localparam int EVT_INC = 1;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_ALARM = 2'd1,
    REG_COUNT = 2'd2,
    REG_STATUS = 2'd3
  } regSel_e;

  typedef struct packed {
    logic restart;
  } ctlStrobe_t;

  typedef struct packed {
    logic inc;
    logic alarm;
  } dpEvent_t;
endpackage

// File: rtl/tick_alarm_dpath.sv
module tick_alarm_dpath
  import tick_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] alarmVal,
  output logic [CNT_W-1:0] countVal,
  output dpEvent_t         evt
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countNext;
  logic             tickNow;

  // prescale 0 wraps to all ones, which gives the full 2^PRE_W period
  assign preLimit = prescale - PRE_ONE;
  assign tickNow = (preCnt == preLimit) && !strobe.restart;
  assign countNext = countQ + CNT_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      countQ <= '0;
    end else if (strobe.restart) begin
      preCnt <= '0;
      countQ <= '0;
    end else if (tickNow) begin
      preCnt <= '0;
      countQ <= countNext;
    end else begin
      preCnt <= preCnt + PRE_ONE;
    end
  end

  assign countVal = countQ;
  assign evt.inc = tickNow;
  assign evt.alarm = tickNow && (countNext == alarmVal) && (alarmVal != ALARM_OFF);

  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (countQ == '0));
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && !evt.inc) |=> $stable(countQ));
  p_step_by_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    evt.inc |=> (countQ == $past(countQ) + CNT_ONE));
endmodule

// File: rtl/tick_alarm_ctrl.sv
module tick_alarm_ctrl
  import tick_alarm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output ctlStrobe_t        strobe,
  output logic [PRE_W-1:0]  prescale,
  output logic [CNT_W-1:0]  alarmVal,
  input  logic [CNT_W-1:0]  countVal,
  input  dpEvent_t          evt
);
  localparam int REG_LSB = 2;

  regSel_e             regIdx;
  logic                wrMode;
  logic                wrAlarm;
  logic                rdStatus;
  logic [PRE_W-1:0]    prescaleQ;
  logic [NUM_EVT-1:0]  enableQ;
  logic [CNT_W-1:0]    alarmQ;
  logic [NUM_EVT-1:0]  statusQ;
  logic [NUM_EVT-1:0]  evtVec;
  logic                unusedBits;

  assign regIdx = regSel_e'(busAddr[REG_LSB +: 2]);
  assign wrMode = busSel && busWrite && (regIdx == REG_MODE);
  assign wrAlarm = busSel && busWrite && (regIdx == REG_ALARM);
  assign rdStatus = busSel && !busWrite && (regIdx == REG_STATUS);
  assign strobe.restart = wrMode && busWdata[RESTART_BIT];
  assign unusedBits = ^{busAddr, busWdata[DATA_W-1:RESTART_BIT+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescaleQ <= PRE_RESET;
      enableQ <= '0;
      alarmQ <= ALARM_OFF;
    end else begin
      if (wrMode) begin
        prescaleQ <= busWdata[PRE_W-1:0];
        enableQ[EVT_ALM] <= busWdata[ALM_EN_BIT];
        enableQ[EVT_INC] <= busWdata[INC_EN_BIT];
      end
      if (wrAlarm) alarmQ <= busWdata[CNT_W-1:0];
    end
  end

  assign evtVec[EVT_ALM] = evt.alarm;
  assign evtVec[EVT_INC] = evt.inc;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else statusQ[i] <= evtVec[i] || (statusQ[i] && !rdStatus);
    end

    p_event_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |=> statusQ[i]);
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
      (rdStatus && !evtVec[i]) |=> !statusQ[i]);
  end

  always_comb begin
    busRdata = '0;
    unique case (regIdx)
      REG_MODE: begin
        busRdata[PRE_W-1:0] = prescaleQ;
        busRdata[ALM_EN_BIT] = enableQ[EVT_ALM];
        busRdata[INC_EN_BIT] = enableQ[EVT_INC];
      end
      REG_ALARM: busRdata[CNT_W-1:0] = alarmQ;
      REG_COUNT: busRdata[CNT_W-1:0] = countVal;
      REG_STATUS: busRdata[NUM_EVT-1:0] = statusQ;
      default: busRdata = '0;
    endcase
  end

  assign irq = |(statusQ & enableQ);
  assign prescale = prescaleQ;
  assign alarmVal = alarmQ;

  p_alarm_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusQ[EVT_ALM]) && !$past(wrAlarm)) |->
      ((countVal == alarmQ) && (alarmQ != ALARM_OFF)));
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
  import tick_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  ctlStrobe_t       strobe;
  dpEvent_t         evt;
  logic [PRE_W-1:0] prescale;
  logic [CNT_W-1:0] alarmVal;
  logic [CNT_W-1:0] countVal;

  tick_alarm_ctrl #(.ADDR_W(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .strobe(strobe), .prescale(prescale), .alarmVal(alarmVal),
    .countVal(countVal), .evt(evt)
  );

  tick_alarm_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescale(prescale),
    .alarmVal(alarmVal), .countVal(countVal), .evt(evt)
  );
endmodule

// File: tb/tick_alarm_timer_bench.sv
module tick_alarm_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] rd;

  localparam logic [3:0] A_MODE = 4'h0, A_ALARM = 4'h4, A_COUNT = 4'h8, A_STAT = 4'hC;
  localparam logic [31:0] B_ALM = 32'h1 << 16, B_INC = 32'h1 << 17, B_RST = 32'h1 << 18;

  always #2 clk = ~clk;

  tick_alarm_timer u_tick_alarm_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rdReg(A_MODE, rd);  chk("R1 mode", rd, 32'h0000_8000);
    rdReg(A_ALARM, rd); chk("R1 alarm", rd, 32'hFFFF_FFFF);
    rdReg(A_COUNT, rd); chk("R1 counter", rd, 32'h0);
    rdReg(A_STAT, rd);  chk("R1 status", rd, 32'h0);
  endtask

  task automatic testPrescale();
    wr(A_MODE, B_RST | 32'd4);
    repeat (3) @(negedge clk);
    rdReg(A_COUNT, rd); chk("R2 before first step", rd, 32'd0);
    rdReg(A_COUNT, rd); chk("R2 first step", rd, 32'd1);
    repeat (7) @(negedge clk);
    rdReg(A_COUNT, rd); chk("R2 third step", rd, 32'd3);
  endtask

  task automatic testRestart();
    wr(A_MODE, B_RST | 32'd3);
    repeat (9) @(negedge clk);
    rdReg(A_COUNT, rd); chk("R4 count before restart", rd, 32'd3);
    wr(A_MODE, B_RST | 32'd3);
    rdReg(A_COUNT, rd); chk("R4 restart clears", rd, 32'd0);
  endtask

  task automatic testReadOnly();
    wr(A_MODE, B_RST | 32'd1000);
    repeat (5) @(negedge clk);
    wr(A_COUNT, 32'h0000_0055);
    rdReg(A_COUNT, rd); chk("R5 counter write ignored", rd, 32'd0);
  endtask

  task automatic testModeReadback();
    wr(A_MODE, 32'hFFF7_1234);
    rdReg(A_MODE, rd); chk("R3 mode readback", rd, 32'h0003_1234);
    wr(A_MODE, 32'h0000_ABCD);
    rdReg(A_MODE, rd); chk("R3 enables cleared", rd, 32'h0000_ABCD);
  endtask

  task automatic testStatusClear();
    wr(A_MODE, B_RST | 32'd10);
    rdReg(A_STAT, rd);
    repeat (9) @(negedge clk);
    rdReg(A_STAT, rd); chk("R7 step flag, no alarm (R6 off value)", rd, 32'h2);
    rdReg(A_STAT, rd); chk("R8 read clears", rd, 32'h0);
  endtask

  task automatic testCollision();
    wr(A_MODE, B_RST | 32'd8);
    rdReg(A_STAT, rd);
    repeat (6) @(negedge clk);
    rdReg(A_STAT, rd); chk("R8 read in step cycle", rd, 32'h0);
    rdReg(A_STAT, rd); chk("R8 coincident event kept", rd, 32'h2);
  endtask

  task automatic testIrqMask();
    wr(A_MODE, B_RST | 32'd10);
    repeat (10) @(negedge clk);
    chk("R9 masked step", {31'b0, irq}, 32'h0);
    wr(A_MODE, B_INC | 32'd10);
    chk("R9 enabled step", {31'b0, irq}, 32'h1);
    rdReg(A_STAT, rd);
    chk("R9 flag read drops irq", {31'b0, irq}, 32'h0);
    wr(A_MODE, 32'd10);
  endtask

  task automatic testAlarm();
    wr(A_ALARM, 32'd3);
    rdReg(A_ALARM, rd); chk("R6 alarm readback", rd, 32'd3);
    rdReg(A_STAT, rd);
    wr(A_MODE, B_RST | B_ALM | 32'd2);
    repeat (5) @(negedge clk);
    chk("R6 no alarm before match", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 alarm at match", {31'b0, irq}, 32'h1);
    rdReg(A_STAT, rd); chk("R6 alarm flag", rd & 32'h1, 32'h1);
    rdReg(A_STAT, rd); chk("R6 no repeat past match", rd & 32'h1, 32'h0);
    wr(A_MODE, 32'd2);
    wr(A_ALARM, 32'hFFFF_FFFF);
  endtask

  task automatic testZeroPrescale();
    wr(A_MODE, B_RST);
    repeat (65535) @(negedge clk);
    rdReg(A_COUNT, rd); chk("R10 no step before 65536", rd, 32'd0);
    rdReg(A_COUNT, rd); chk("R10 step at 65536", rd, 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPrescale();
    testRestart();
    testReadOnly();
    testModeReadback();
    testStatusClear();
    testCollision();
    testIrqMask();
    testAlarm();
    testZeroPrescale();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule